// File: doc/BRIEF.md
# TDM Audio Slot Port

This block is the serial side of a time-division multiplexed audio highway. Each frame opens with a frame sync pulse that recurs at 8 kHz, and a data clock paces the bits. The block carries one receive and one transmit audio channel. Each channel sits on either of two shared data lines and has its own bit-granular start position and length, counted from the frame sync. How many slots a frame holds is never programmed. It follows from how many data-clock periods pass before the next sync.

The data clock and frame sync are sampled on the fast system clock `clk_i`. In single-rate mode one data-clock period carries one bit. In double-rate mode two periods carry one bit. Transmit bits launch on the rising data-clock edge and receive bits are captured on a falling edge. The processor side has a transmit holding word and a receive holding word. Each is swapped with the shift side at a slot boundary, so software can access it at any point in the frame. An interrupt pulse marks either the frame start or the point where a programmed number of transmit bits has left the port. Outside its own transmit slot the port drives neither line. Each line can also run with open-drain drive.

Top module: `tdm_audio_port`

## Requirements
- R1: After reset, both line enables `dl_oe_o` are 0, `rx_vld_o`, `rx_ovr_o` and `irq_o` are 0, and `rx_rdata_o` is 0. No line is driven before the first frame sync has been seen.
- R2: Frame bit 1 starts at the first rising data-clock edge at which `fsync_i` is high after having been low at the previous rising edge. Each further bit starts at the next rising edge in single rate (`dbl_rate_i`=0), or at every second rising edge in double rate (`dbl_rate_i`=1).
- R3: Slot placement is set by a start code and a length code. The start code S (0..511) places the first slot bit at frame bit S+1, so frame bits 1..512 are reachable. The length code L (0..31) gives L+1 bits. The transmit slot drives only the line chosen by `tx_line_i` (0 or 1), with enable high during exactly those bits. It sends the low L+1 bits of the active word, most significant bit first.
- R4: In single rate, receive bits are sampled on the first falling data-clock edge of each bit; in double rate, on the second. The received word appears on `rx_rdata_o`, right-aligned with the first bit most significant and upper bits zero. It appears once the last slot bit is sampled, and `rx_vld_o` is then set.
- R5: A word written with `tx_wr_i` at any time is sent in the next transmit slot that starts after the write. If no new word is written, the previous word is sent again.
- R6: `rx_ovr_o` is set when a new receive word completes while `rx_vld_o` is still set. A `rx_rd_i` pulse clears both `rx_vld_o` and `rx_ovr_o`.
- R7: With `open_drain_i`=1 the port enables its line only for 0 bits, and the line data it presents is 0 whenever the line is enabled.
- R8: With `irq_mode_i`=0, `irq_o` pulses for one cycle once per frame, right after the frame start edge.
- R9: With `irq_mode_i`=1 and count code N (0..31), `irq_o` pulses once per frame, at the start of the frame bit that follows transmit slot bit N+1. No pulse occurs when N+1 exceeds the slot length.
- R10: The receive channel takes its bits only from the line chosen by `rx_line_i`, independently of the transmit line choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the highway |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dclk_i | input | 1 | Highway data clock |
| fsync_i | input | 1 | Frame sync, high at frame start |
| dbl_rate_i | input | 1 | 1: two data-clock periods per bit |
| open_drain_i | input | 1 | 1: drive only zero bits |
| irq_mode_i | input | 1 | 0: per-frame interrupt, 1: after counted transmit bits |
| irq_bits_i | input | 5 | Interrupt bit count minus one |
| rx_line_i | input | 1 | Receive line select |
| rx_start_i | input | 9 | Receive slot start code |
| rx_len_i | input | 5 | Receive slot length minus one |
| tx_line_i | input | 1 | Transmit line select |
| tx_start_i | input | 9 | Transmit slot start code |
| tx_len_i | input | 5 | Transmit slot length minus one |
| tx_wr_i | input | 1 | Write strobe for the transmit holding word |
| tx_wdata_i | input | 32 | Transmit holding word |
| rx_rd_i | input | 1 | Read acknowledge for the receive word |
| rx_rdata_o | output | 32 | Last completed receive word |
| rx_vld_o | output | 1 | Unread receive word present |
| rx_ovr_o | output | 1 | Receive word overwritten before read |
| irq_o | output | 1 | Transfer interrupt pulse |
| dl_i | input | 2 | Data line input levels |
| dl_o | output | 2 | Data line drive values |
| dl_oe_o | output | 2 | Data line drive enables |

## Verification
A wrong bit counter or half-bit phase shows up within one frame. The line enable then appears on the wrong frame bits, and the received word is shifted or carries bits from the deselected line. The bench drives the unselected line with inverted data, so a wrong line choice corrupts every bit. A holding register that is swapped at the wrong moment sends the previous word in the next slot. Stale overrun or valid state is visible on the status outputs right after the second unread slot. A mis-timed interrupt is located to the exact frame bit in which the pulse appears.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
  localparam int unsigned START_W   = 9;
  localparam int unsigned LEN_W     = 5;
  localparam int unsigned WORD_W    = 1 << LEN_W;
  localparam int unsigned IDX_W     = START_W + 1;
  localparam int unsigned NUM_LINES = 2;

  typedef struct packed {
    logic               line;
    logic [START_W-1:0] start;
    logic [LEN_W-1:0]   len;
  } slot_cfg_t;

  function automatic logic in_slot(input logic [IDX_W-1:0] idx, input slot_cfg_t c);
    logic [IDX_W-1:0] s, e;
    s = IDX_W'(c.start);
    e = s + IDX_W'(c.len);
    return (idx >= s) && (idx <= e);
  endfunction

  function automatic logic [LEN_W-1:0] slot_ofs(input logic [IDX_W-1:0] idx, input slot_cfg_t c);
    logic [IDX_W-1:0] d;
    d = idx - IDX_W'(c.start);
    return d[LEN_W-1:0];
  endfunction
endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer
  import tdm_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dclk_i,
  input  logic             fsync_i,
  input  logic             dbl_rate_i,
  output logic             bit_start_o,
  output logic             frame_start_o,
  output logic             sample_o,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             dclk_q, fs_at_rise_q, run_q, half_q;
  logic [IDX_W-1:0] idx_q;
  logic             rise, fall, fs_edge, adv;

  always_comb begin
    rise    = dclk_i & ~dclk_q;
    fall    = ~dclk_i & dclk_q;
    fs_edge = rise & fsync_i & ~fs_at_rise_q;
    adv     = rise & ~fs_edge & run_q & (~dbl_rate_i | half_q);
    if (fs_edge)               nxt_idx_o = '0;
    else if (idx_q == IDX_MAX) nxt_idx_o = idx_q;
    else                       nxt_idx_o = idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_q       <= 1'b0;
      fs_at_rise_q <= 1'b0;
      run_q        <= 1'b0;
      half_q       <= 1'b0;
      idx_q        <= '0;
    end else begin
      dclk_q <= dclk_i;
      if (rise) fs_at_rise_q <= fsync_i;
      if (fs_edge) begin
        run_q  <= 1'b1;
        half_q <= 1'b0;
        idx_q  <= '0;
      end else if (rise && run_q) begin
        half_q <= dbl_rate_i & ~half_q;
        if (adv) idx_q <= nxt_idx_o;
      end
    end
  end

  assign bit_start_o   = fs_edge | adv;
  assign frame_start_o = fs_edge;
  // double rate samples on the falling edge of the second clock period
  assign sample_o      = fall & run_q & (~dbl_rate_i | half_q);
  assign idx_o         = idx_q;
endmodule

// File: rtl/tdm_tx_chan.sv
module tdm_tx_chan
  import tdm_port_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  slot_cfg_t            cfg_i,
  input  logic                 open_drain_i,
  input  logic                 bit_start_i,
  input  logic [IDX_W-1:0]     nxt_idx_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 wr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic [LEN_W-1:0]     irq_bits_i,
  output logic [NUM_LINES-1:0] line_o,
  output logic [NUM_LINES-1:0] oe_o,
  output logic                 bits_hit_o
);
  logic [WORD_W-1:0] pend_q, cur_q, word;
  logic [LEN_W-1:0]  ofs, prev_ofs_q;
  logic              in_nxt, first;
  logic              prev_in_q, drv_oe_q, drv_bit_q, drv_line_q;

  always_comb begin
    in_nxt = in_slot(nxt_idx_i, cfg_i);
    ofs    = slot_ofs(nxt_idx_i, cfg_i);
    first  = in_nxt && (ofs == '0);
    // swap happens as the slot opens, so bit 0 already uses the new word
    word   = first ? pend_q : cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      cur_q      <= '0;
      prev_ofs_q <= '0;
      prev_in_q  <= 1'b0;
      drv_oe_q   <= 1'b0;
      drv_bit_q  <= 1'b0;
      drv_line_q <= 1'b0;
    end else begin
      if (wr_i) pend_q <= wdata_i;
      if (bit_start_i) begin
        if (first) cur_q <= pend_q;
        drv_oe_q   <= in_nxt;
        drv_bit_q  <= word[cfg_i.len - ofs];
        drv_line_q <= cfg_i.line;
        prev_in_q  <= in_nxt;
        prev_ofs_q <= ofs;
      end
    end
  end

  assign bits_hit_o = bit_start_i & prev_in_q & (prev_ofs_q == irq_bits_i);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign line_o[l] = ~open_drain_i & drv_bit_q;
    assign oe_o[l]   = drv_oe_q & (drv_line_q == 1'(l)) & (~open_drain_i | ~drv_bit_q);
  end

  AST_TX_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|oe_o) |-> in_slot(idx_i, cfg_i)) else $error("tx drive outside slot"); // R3
  AST_TX_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(oe_o)) else $error("tx drives both lines"); // R3
endmodule

// File: rtl/tdm_rx_chan.sv
module tdm_rx_chan
  import tdm_port_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  slot_cfg_t            cfg_i,
  input  logic                 sample_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 rd_i,
  output logic [WORD_W-1:0]    data_o,
  output logic                 vld_o,
  output logic                 ovr_o
);
  logic [WORD_W-1:0] sh_q, sh_nxt, buf_q;
  logic [LEN_W-1:0]  ofs;
  logic              in_cur, bit_in, done, vld_q, ovr_q;

  always_comb begin
    in_cur = in_slot(idx_i, cfg_i);
    ofs    = slot_ofs(idx_i, cfg_i);
    bit_in = line_i[cfg_i.line];
    sh_nxt = (ofs == '0) ? WORD_W'(bit_in) : {sh_q[WORD_W-2:0], bit_in};
    done   = sample_i & in_cur & (ofs == cfg_i.len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      buf_q <= '0;
      vld_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (rd_i) begin
        vld_q <= 1'b0;
        ovr_q <= 1'b0;
      end
      if (sample_i && in_cur) sh_q <= sh_nxt;
      if (done) begin
        buf_q <= sh_nxt;
        vld_q <= 1'b1;
        if (vld_q && !rd_i) ovr_q <= 1'b1;
      end
    end
  end

  assign data_o = buf_q;
  assign vld_o  = vld_q;
  assign ovr_o  = ovr_q;

  AST_RX_VLD_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_q) |-> $past(sample_i)) else $error("rx valid without sample"); // R4
  AST_RX_OVR_NEEDS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(vld_q)) else $error("overrun without pending word"); // R6
endmodule

// File: rtl/tdm_audio_port.sv
module tdm_audio_port
  import tdm_port_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dclk_i,
  input  logic                 fsync_i,
  input  logic                 dbl_rate_i,
  input  logic                 open_drain_i,
  input  logic                 irq_mode_i,
  input  logic [LEN_W-1:0]     irq_bits_i,
  input  logic                 rx_line_i,
  input  logic [START_W-1:0]   rx_start_i,
  input  logic [LEN_W-1:0]     rx_len_i,
  input  logic                 tx_line_i,
  input  logic [START_W-1:0]   tx_start_i,
  input  logic [LEN_W-1:0]     tx_len_i,
  input  logic                 tx_wr_i,
  input  logic [WORD_W-1:0]    tx_wdata_i,
  input  logic                 rx_rd_i,
  output logic [WORD_W-1:0]    rx_rdata_o,
  output logic                 rx_vld_o,
  output logic                 rx_ovr_o,
  output logic                 irq_o,
  input  logic [NUM_LINES-1:0] dl_i,
  output logic [NUM_LINES-1:0] dl_o,
  output logic [NUM_LINES-1:0] dl_oe_o
);
  logic             bit_start, frame_start, sample, bits_hit, irq_q;
  logic [IDX_W-1:0] nxt_idx, idx;
  slot_cfg_t        rx_cfg, tx_cfg;

  assign rx_cfg = '{line: rx_line_i, start: rx_start_i, len: rx_len_i};
  assign tx_cfg = '{line: tx_line_i, start: tx_start_i, len: tx_len_i};

  tdm_bit_timer u_timer (
    .clk_i, .rst_ni, .dclk_i, .fsync_i, .dbl_rate_i,
    .bit_start_o(bit_start), .frame_start_o(frame_start), .sample_o(sample),
    .nxt_idx_o(nxt_idx), .idx_o(idx)
  );

  tdm_tx_chan u_tx (
    .clk_i, .rst_ni, .cfg_i(tx_cfg), .open_drain_i,
    .bit_start_i(bit_start), .nxt_idx_i(nxt_idx), .idx_i(idx),
    .wr_i(tx_wr_i), .wdata_i(tx_wdata_i), .irq_bits_i,
    .line_o(dl_o), .oe_o(dl_oe_o), .bits_hit_o(bits_hit)
  );

  tdm_rx_chan u_rx (
    .clk_i, .rst_ni, .cfg_i(rx_cfg), .sample_i(sample), .idx_i(idx),
    .line_i(dl_i), .rd_i(rx_rd_i),
    .data_o(rx_rdata_o), .vld_o(rx_vld_o), .ovr_o(rx_ovr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_mode_i ? bits_hit : frame_start;
  end
  assign irq_o = irq_q;

  AST_IRQ_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_mode_i) |-> $past(frame_start)) else $error("frame irq off frame start"); // R8
endmodule

// File: tb/tdm_audio_port_tb.sv
module tdm_audio_port_tb_top;
  import tdm_port_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic dclk = 0, fsync = 0, dbl = 0, od = 0, irq_mode = 0;
  logic [LEN_W-1:0] irq_bits = '0;
  logic rx_line = 0, tx_line = 0;
  logic [START_W-1:0] rx_start = '0, tx_start = '0;
  logic [LEN_W-1:0] rx_len = '0, tx_len = '0;
  logic tx_wr = 0, rx_rd = 0;
  logic [WORD_W-1:0] tx_wdata = '0;
  logic [WORD_W-1:0] rx_rdata;
  logic rx_vld, rx_ovr, irq;
  logic [1:0] dl_in = '0, dl_out, dl_oe;

  tdm_audio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dclk_i(dclk), .fsync_i(fsync),
    .dbl_rate_i(dbl), .open_drain_i(od), .irq_mode_i(irq_mode), .irq_bits_i(irq_bits),
    .rx_line_i(rx_line), .rx_start_i(rx_start), .rx_len_i(rx_len),
    .tx_line_i(tx_line), .tx_start_i(tx_start), .tx_len_i(tx_len),
    .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata), .rx_rd_i(rx_rd),
    .rx_rdata_o(rx_rdata), .rx_vld_o(rx_vld), .rx_ovr_o(rx_ovr), .irq_o(irq),
    .dl_i(dl_in), .dl_o(dl_out), .dl_oe_o(dl_oe)
  );

  int n_chk = 0, n_fail = 0, irq_cnt = 0, first_irq = -1;
  bit done = 0;
  logic rx_bits [0:1023];
  logic [1:0] cap_oe [0:1023];
  logic [1:0] cap_d  [0:1023];

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_rx(input int seed);
    for (int b = 0; b < 1024; b++) rx_bits[b] = ((b * 5 + seed) % 3) == 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input int nbits);
    int base;
    base = irq_cnt;
    first_irq = -1;
    for (int b = 0; b < nbits; b++) begin
      dclk = 1; fsync = (b == 0);
      dl_in[rx_line]  = rx_bits[b];
      dl_in[!rx_line] = ~rx_bits[b];
      wait_n(4);
      cap_oe[b] = dl_oe; cap_d[b] = dl_out;
      if (first_irq < 0 && irq_cnt != base) first_irq = b;
      dclk = 0;
      wait_n(4);
      if (dbl) begin
        dclk = 1; fsync = 0;
        wait_n(4);
        dclk = 0;
        wait_n(4);
      end
    end
    fsync = 0;
    wait_n(4);
  endtask

  task automatic write_tx(input logic [31:0] w);
    tx_wdata = w; tx_wr = 1; wait_n(1); tx_wr = 0;
  endtask

  task automatic read_rx();
    rx_rd = 1; wait_n(1); rx_rd = 0;
  endtask

  task automatic check_tx(input string req, input int nbits, input logic [31:0] w);
    int errs = 0;
    for (int b = 0; b < nbits; b++)
      for (int l = 0; l < 2; l++) begin
        bit in, bv, eoe;
        in  = (l == int'(tx_line)) && b >= int'(tx_start) && b <= int'(tx_start) + int'(tx_len);
        bv  = in ? w[int'(tx_len) - (b - int'(tx_start))] : 1'b0;
        eoe = in && (!od || !bv);
        if (cap_oe[b][l] !== eoe) errs++;
        else if (eoe && cap_d[b][l] !== (od ? 1'b0 : bv)) errs++;
      end
    chk(errs == 0, req, errs, 0);
  endtask

  function automatic logic [31:0] exp_rx();
    logic [31:0] v = '0;
    for (int k = 0; k <= int'(rx_len); k++) v = (v << 1) | 32'(rx_bits[int'(rx_start) + k]);
    return v;
  endfunction

  task automatic t_reset();
    chk(dl_oe === 2'b00, "R1 oe", 32'(dl_oe), 0);
    chk(rx_vld === 0 && rx_ovr === 0 && irq === 0, "R1 status", {rx_vld, rx_ovr, irq}, 0);
    chk(rx_rdata === '0, "R1 rdata", rx_rdata, 0);
    dclk = 1; wait_n(4); dclk = 0; wait_n(4);
    chk(dl_oe === 2'b00, "R1 no drive before sync", 32'(dl_oe), 0);
  endtask

  task automatic t_single();
    dbl = 0; od = 0; irq_mode = 0;
    tx_line = 0; tx_start = 4; tx_len = 7;
    rx_line = 1; rx_start = 10; rx_len = 11;
    fill_rx(1); write_tx(32'h0000_00A5);
    run_frame(48);
    check_tx("R2 R3 single-rate tx", 48, 32'hA5);
    chk(rx_rdata === exp_rx(), "R4 R10 single-rate rx", rx_rdata, exp_rx());
    chk(rx_vld === 1, "R4 vld", 32'(rx_vld), 1);
    chk(irq_cnt == 1 && first_irq == 0, "R8 frame irq", irq_cnt * 256 + first_irq, 256);
  endtask

  task automatic t_double();
    int c0;
    dbl = 1; read_rx();
    tx_line = 1; tx_start = 0; tx_len = 31;
    rx_line = 0; rx_start = 0; rx_len = 31;
    fill_rx(2); write_tx(32'hDEAD_BEEF);
    c0 = irq_cnt;
    run_frame(40);
    check_tx("R2 R3 double-rate tx", 40, 32'hDEADBEEF);
    chk(rx_rdata === exp_rx(), "R4 R10 double-rate rx", rx_rdata, exp_rx());
    chk(irq_cnt - c0 == 1, "R8 one irq per frame", irq_cnt - c0, 1);
  endtask

  task automatic t_repeat_ovr();
    fill_rx(0);
    run_frame(40);
    check_tx("R5 repeat last word", 40, 32'hDEADBEEF);
    chk(rx_rdata === exp_rx(), "R4 second word", rx_rdata, exp_rx());
    chk(rx_ovr === 1 && rx_vld === 1, "R6 overrun set", {rx_ovr, rx_vld}, 3);
    read_rx();
    chk(rx_ovr === 0 && rx_vld === 0, "R6 read clears", {rx_ovr, rx_vld}, 0);
  endtask

  task automatic t_open_drain();
    dbl = 0; od = 1;
    tx_line = 0; tx_start = 6; tx_len = 15;
    write_tx(32'h0000_5A3C);
    run_frame(30);
    check_tx("R7 R5 open-drain tx", 30, 32'h5A3C);
    od = 0;
  endtask

  task automatic t_irq_bits();
    int c0;
    irq_mode = 1; irq_bits = 4;
    tx_line = 1; tx_start = 8; tx_len = 7;
    c0 = irq_cnt;
    run_frame(30);
    chk(irq_cnt - c0 == 1, "R9 count irq once", irq_cnt - c0, 1);
    chk(first_irq == 13, "R9 irq bit position", first_irq, 13);
    irq_bits = 20; c0 = irq_cnt;
    run_frame(30);
    chk(irq_cnt == c0, "R9 count beyond slot", irq_cnt - c0, 0);
    irq_mode = 0;
  endtask

  task automatic t_far();
    read_rx();
    tx_line = 1; tx_start = 511; tx_len = 31;
    rx_line = 1; rx_start = 511; rx_len = 31;
    fill_rx(7); write_tx(32'h8000_0001);
    run_frame(544);
    check_tx("R3 last start position", 544, 32'h80000001);
    chk(rx_rdata === exp_rx(), "R4 last start position rx", rx_rdata, exp_rx());
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    t_reset();
    t_single();
    t_double();
    t_repeat_ovr();
    t_open_drain();
    t_irq_bits();
    t_far();
    done = 1;
    summary();
    $finish;
  end
endmodule